// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This block works out the effective memory type of a physical address window. A requester presents a start address and an exclusive end address with a one-cycle strobe. One clock later the unit returns an 8-bit type code. The code comes from one of four places: a table of 88 per-slot type bytes that covers the lowest megabyte, a set of variable ranges each defined by a base and a mask, a default type, or an optional upper-memory limit above 4 GiB that forces write-back.

Configuration comes in over simple write strobes: a default/enable word, the base or mask word of one variable range, one fixed-table byte, and the upper-memory limit. Two codes are reserved for special results. 0xFF means the unit holds no usable state. 0xFE means the window is only partly covered by a variable range. Type codes are uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05 and write-back 0x06.

Top module: `mtype_lookup`

## Requirements
- R1: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high. `rsp_type` holds the result computed from the request and the configuration present in that request cycle.
- R2: The result is 0xFF when no default/enable word has been written since reset, or when both enable bits of that word are clear.
- R3: `req_end` is exclusive. The last address checked against the variable ranges is `req_end - 1`.
- R4: When the fixed table exists and start is below 0x100000, the result is the fixed byte picked by start alone. The slot is start>>16 below 0x80000. It is 8 + ((start-0x80000)>>14) below 0xC0000. Otherwise it is 24 + ((start-0xC0000)>>12).
- R5: In the default/enable word, bits [7:0] hold the default type, bit 10 the fixed enable and bit 11 the variable enable. If the variable enable is clear and the fixed table does not apply, the result is the default type.
- R6: A variable range counts only when bit 11 of its mask word is set. Its type is bits [7:0] of its base word. Base and mask are compared on address bits 12 and up.
- R7: If start matches a counting range and last does not, or last matches and start does not, the result is 0xFE.
- R8: If two or more ranges match and any of them is uncacheable, the result is uncacheable.
- R9: A matching write-back range together with a matching write-through range gives write-through.
- R10: Matching ranges with equal types give that type. Any other type mismatch gives uncacheable.
- R11: When the upper-memory limit is nonzero, start is at least 4 GiB and last is below the limit, and the scan ended without a decisive outcome, the result is write-back.
- R12: When no counting range matches, the result is the default type.
- R13: Ranges are scanned in ascending index order. The first straddle or conflict ends the scan, so later ranges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| def_we | input | 1 | Write strobe for the default/enable word |
| def_wdata | input | 12 | Default type [7:0], fixed enable [10], variable enable [11] |
| var_we | input | 1 | Write strobe for a variable range word |
| var_idx | input | IDX_W | Variable range index |
| var_sel_mask | input | 1 | 1 writes the mask word, 0 writes the base word |
| var_wdata | input | ADDR_W | Base word (type [7:0]) or mask word (valid [11]) |
| fix_we | input | 1 | Write strobe for a fixed-table byte |
| fix_idx | input | 7 | Fixed slot 0..87; higher values are dropped |
| fix_wdata | input | 8 | Fixed slot type |
| tom2_we | input | 1 | Write strobe for the upper-memory limit |
| tom2_wdata | input | ADDR_W | Upper-memory limit, exclusive |
| req_valid | input | 1 | Lookup request strobe |
| req_start | input | ADDR_W | Window start address |
| req_end | input | ADDR_W | Window end address, exclusive |
| rsp_valid | output | 1 | Result strobe |
| rsp_type | output | 8 | Effective type or special code |

## Verification
The assertions assume that `req_valid` and the write strobes are 0 or 1 on every clock after reset. They also assume that a write in the cycle before a request takes effect for that request. The start-only property for the fixed table assumes that no write lands between two back-to-back requests. Each bench task drives writes and requests on separate falling edges and waits a full cycle between them. It also issues one back-to-back pair with no write between, so every stimulus stays inside these assumptions.

// File: rtl/mtype_pkg.sv
package mtype_pkg;

   localparam logic [7:0] MT_UC = 8'h00;
   localparam logic [7:0] MT_WC = 8'h01;
   localparam logic [7:0] MT_WT = 8'h04;
   localparam logic [7:0] MT_WP = 8'h05;
   localparam logic [7:0] MT_WB = 8'h06;
   localparam logic [7:0] MT_PARTIAL = 8'hFE;
   localparam logic [7:0] MT_OFF     = 8'hFF;

   localparam int FIX_SLOTS = 88;

   typedef struct packed {
      logic       done;
      logic [7:0] res;
      logic       hit;
      logic [7:0] prev;
   } scan_t;

   localparam scan_t SCAN_INIT = '{done: 1'b0, res: 8'h00, hit: 1'b0, prev: 8'h00};

   function automatic scan_t scan_step(input scan_t s, input logic vld,
                                       input logic strad, input logic hit,
                                       input logic [7:0] ty);
      scan_t      r;
      logic [7:0] p;
      logic [7:0] c;
      r = s;
      p = s.prev;
      c = ty;
      if (!s.done && vld) begin
         if (strad) begin
            r.done = 1'b1;
            r.res  = MT_PARTIAL;
         end else if (hit) begin
            if (!s.hit) begin
               r.hit  = 1'b1;
               r.prev = ty;
            end else if (s.prev == MT_UC || ty == MT_UC) begin
               r.done = 1'b1;
               r.res  = MT_UC;
            end else begin
               if ((p == MT_WB && c == MT_WT) || (p == MT_WT && c == MT_WB)) begin
                  p = MT_WT;
                  c = MT_WT;
               end
               r.prev = p;
               if (p != c) begin
                  r.done = 1'b1;
                  r.res  = MT_UC;
               end
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/mtype_cfg_regs.sv
module mtype_cfg_regs
   import mtype_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int NUM_VAR    = 8,
   parameter int PAGE_SHIFT = 12,
   parameter bit HAVE_FIXED = 1'b1,
   parameter bit HAVE_TOM2  = 1'b1,
   localparam int IDX_W     = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1,
   localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              def_we,
   input  logic [11:0]       def_wdata,
   input  logic              var_we,
   input  logic [IDX_W-1:0]  var_idx,
   input  logic              var_sel_mask,
   input  logic [ADDR_W-1:0] var_wdata,
   input  logic              fix_we,
   input  logic [6:0]        fix_idx,
   input  logic [7:0]        fix_wdata,
   input  logic              tom2_we,
   input  logic [ADDR_W-1:0] tom2_wdata,
   output logic              loaded,
   output logic [7:0]        def_type,
   output logic              fix_en,
   output logic              var_en,
   output logic [PG_W-1:0]   var_base [NUM_VAR],
   output logic [PG_W-1:0]   var_mask [NUM_VAR],
   output logic [7:0]        var_type [NUM_VAR],
   output logic              var_vld  [NUM_VAR],
   output logic [7:0]        fix_tab  [FIX_SLOTS],
   output logic [ADDR_W-1:0] tom2
);

   logic unused_wbits;
   assign unused_wbits = ^{def_wdata[9:8], var_wdata[10:8], var_wdata[PAGE_SHIFT-1:12]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded   <= 1'b0;
         def_type <= 8'h00;
         fix_en   <= 1'b0;
         var_en   <= 1'b0;
      end else if (def_we) begin
         loaded   <= 1'b1;
         def_type <= def_wdata[7:0];
         fix_en   <= def_wdata[10];
         var_en   <= def_wdata[11];
      end
   end

   for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            var_base[i] <= '0;
            var_type[i] <= 8'h00;
            var_mask[i] <= '0;
            var_vld[i]  <= 1'b0;
         end else if (var_we && int'(var_idx) == i) begin
            if (var_sel_mask) begin
               var_mask[i] <= var_wdata[ADDR_W-1:PAGE_SHIFT];
               var_vld[i]  <= var_wdata[11];
            end else begin
               var_base[i] <= var_wdata[ADDR_W-1:PAGE_SHIFT];
               var_type[i] <= var_wdata[7:0];
            end
         end
      end
   end

   if (HAVE_FIXED) begin : g_fix
      for (genvar j = 0; j < FIX_SLOTS; j++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fix_tab[j] <= 8'h00;
            else if (fix_we && int'(fix_idx) == j)
               fix_tab[j] <= fix_wdata;
         end
      end
   end else begin : g_nofix
      for (genvar j = 0; j < FIX_SLOTS; j++) begin : g_slot
         assign fix_tab[j] = 8'h00;
      end
      logic unused_fix;
      assign unused_fix = ^{fix_we, fix_idx, fix_wdata};
   end

   if (HAVE_TOM2) begin : g_tom2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tom2 <= '0;
         else if (tom2_we)
            tom2 <= tom2_wdata;
      end
   end else begin : g_notom2
      assign tom2 = '0;
      logic unused_tom2;
      assign unused_tom2 = ^{tom2_we, tom2_wdata};
   end

endmodule

// File: rtl/mtype_fixed_pick.sv
module mtype_fixed_pick
   import mtype_pkg::*;
#(
   parameter bit HAVE_FIXED = 1'b1
) (
   input  logic [7:0] start_pg,
   input  logic [7:0] fix_tab [FIX_SLOTS],
   output logic [7:0] fix_type
);

   if (HAVE_FIXED) begin : g_on
      logic [6:0] slot;
      always_comb begin
         if (!start_pg[7])
            slot = {4'd0, start_pg[6:4]};
         else if (!start_pg[6])
            slot = 7'd8 + {3'd0, start_pg[5:2]};
         else
            slot = 7'd24 + {1'b0, start_pg[5:0]};
      end
      assign fix_type = fix_tab[slot];
   end else begin : g_off
      assign fix_type = 8'h00;
      logic unused_pg;
      assign unused_pg = ^{start_pg, fix_tab[0]};
   end

endmodule

// File: rtl/mtype_var_resolve.sv
module mtype_var_resolve
   import mtype_pkg::*;
#(
   parameter int PG_W    = 28,
   parameter int NUM_VAR = 8
) (
   input  logic [PG_W-1:0] start_pg,
   input  logic [PG_W-1:0] last_pg,
   input  logic [PG_W-1:0] var_base [NUM_VAR],
   input  logic [PG_W-1:0] var_mask [NUM_VAR],
   input  logic [7:0]      var_type [NUM_VAR],
   input  logic            var_vld  [NUM_VAR],
   output scan_t           result
);

   scan_t chain [NUM_VAR+1];
   assign chain[0] = SCAN_INIT;

   for (genvar i = 0; i < NUM_VAR; i++) begin : g_rng
      logic [PG_W-1:0] ref_pg;
      logic            s_in;
      logic            l_in;
      assign ref_pg = var_base[i] & var_mask[i];
      assign s_in   = ((start_pg & var_mask[i]) == ref_pg);
      assign l_in   = ((last_pg  & var_mask[i]) == ref_pg);
      assign chain[i+1] = scan_step(chain[i], var_vld[i], s_in != l_in, s_in, var_type[i]);
   end

   assign result = chain[NUM_VAR];

endmodule

// File: rtl/mtype_lookup.sv
module mtype_lookup
   import mtype_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int NUM_VAR    = 8,
   parameter int PAGE_SHIFT = 12,
   parameter bit HAVE_FIXED = 1'b1,
   parameter bit HAVE_TOM2  = 1'b1,
   localparam int IDX_W     = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1,
   localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              def_we,
   input  logic [11:0]       def_wdata,
   input  logic              var_we,
   input  logic [IDX_W-1:0]  var_idx,
   input  logic              var_sel_mask,
   input  logic [ADDR_W-1:0] var_wdata,
   input  logic              fix_we,
   input  logic [6:0]        fix_idx,
   input  logic [7:0]        fix_wdata,
   input  logic              tom2_we,
   input  logic [ADDR_W-1:0] tom2_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   output logic              rsp_valid,
   output logic [7:0]        rsp_type
);

   if (ADDR_W < 33) begin : g_bad_addr
      $error("mtype_lookup: ADDR_W must be at least 33");
   end
   if (PAGE_SHIFT != 12) begin : g_bad_page
      $error("mtype_lookup: PAGE_SHIFT must be 12");
   end
   if (NUM_VAR < 1 || NUM_VAR > 64) begin : g_bad_num
      $error("mtype_lookup: NUM_VAR must be in 1..64");
   end

   logic              loaded, fix_en, var_en;
   logic [7:0]        def_type;
   logic [PG_W-1:0]   var_base [NUM_VAR];
   logic [PG_W-1:0]   var_mask [NUM_VAR];
   logic [7:0]        var_type [NUM_VAR];
   logic              var_vld  [NUM_VAR];
   logic [7:0]        fix_tab  [FIX_SLOTS];
   logic [ADDR_W-1:0] tom2;

   mtype_cfg_regs #(
      .ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .PAGE_SHIFT(PAGE_SHIFT),
      .HAVE_FIXED(HAVE_FIXED), .HAVE_TOM2(HAVE_TOM2)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .def_we(def_we), .def_wdata(def_wdata),
      .var_we(var_we), .var_idx(var_idx), .var_sel_mask(var_sel_mask), .var_wdata(var_wdata),
      .fix_we(fix_we), .fix_idx(fix_idx), .fix_wdata(fix_wdata),
      .tom2_we(tom2_we), .tom2_wdata(tom2_wdata),
      .loaded(loaded), .def_type(def_type), .fix_en(fix_en), .var_en(var_en),
      .var_base(var_base), .var_mask(var_mask), .var_type(var_type), .var_vld(var_vld),
      .fix_tab(fix_tab), .tom2(tom2)
   );

   logic [ADDR_W-1:0] req_last;
   assign req_last = req_end - 1'b1;

   logic [7:0] fix_type;
   mtype_fixed_pick #(.HAVE_FIXED(HAVE_FIXED)) u_fix (
      .start_pg(req_start[19:12]), .fix_tab(fix_tab), .fix_type(fix_type)
   );

   scan_t scan;
   mtype_var_resolve #(.PG_W(PG_W), .NUM_VAR(NUM_VAR)) u_var (
      .start_pg(req_start[ADDR_W-1:PAGE_SHIFT]), .last_pg(req_last[ADDR_W-1:PAGE_SHIFT]),
      .var_base(var_base), .var_mask(var_mask), .var_type(var_type), .var_vld(var_vld),
      .result(scan)
   );

   logic in_low_mb;
   assign in_low_mb = HAVE_FIXED && (req_start[ADDR_W-1:20] == '0);

   logic tom2_hit;
   if (HAVE_TOM2) begin : g_t2
      assign tom2_hit = (tom2 != '0) && (req_start[ADDR_W-1:32] != '0) && (req_last < tom2);
   end else begin : g_not2
      assign tom2_hit = 1'b0;
   end

   logic unused_low;
   assign unused_low = ^{req_start[11:0], req_last[PAGE_SHIFT-1:0]};

   logic [7:0] next_type;
   always_comb begin
      if (!loaded || !(fix_en || var_en))
         next_type = MT_OFF;
      else if (in_low_mb)
         next_type = fix_type;
      else if (!var_en)
         next_type = def_type;
      else if (scan.done)
         next_type = scan.res;
      else if (tom2_hit)
         next_type = MT_WB;
      else if (scan.hit)
         next_type = scan.prev;
      else
         next_type = def_type;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_type  <= 8'h00;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid)
            rsp_type <= next_type;
      end
   end

endmodule

// File: rtl/mtype_lookup_chk.sv
module mtype_lookup_chk #(
   parameter int ADDR_W     = 40,
   parameter int NUM_VAR    = 8,
   parameter bit HAVE_FIXED = 1'b1,
   localparam int IDX_W     = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              def_we,
   input logic [11:0]       def_wdata,
   input logic              var_we,
   input logic [IDX_W-1:0]  var_idx,
   input logic              var_sel_mask,
   input logic [ADDR_W-1:0] var_wdata,
   input logic              fix_we,
   input logic [6:0]        fix_idx,
   input logic [7:0]        fix_wdata,
   input logic              tom2_we,
   input logic [ADDR_W-1:0] tom2_wdata,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_start,
   input logic [ADDR_W-1:0] req_end,
   input logic              rsp_valid,
   input logic [7:0]        rsp_type
);

   logic              seen_def;
   logic [1:0]        en_q;
   logic [7:0]        dflt_q;
   logic              wr_q;
   logic              prev_req;
   logic [ADDR_W-1:0] prev_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_def   <= 1'b0;
         en_q       <= 2'b00;
         dflt_q     <= 8'h00;
         wr_q       <= 1'b0;
         prev_req   <= 1'b0;
         prev_start <= '0;
      end else begin
         if (def_we) begin
            seen_def <= 1'b1;
            en_q     <= {def_wdata[11], def_wdata[10]};
            dflt_q   <= def_wdata[7:0];
         end
         wr_q       <= def_we | var_we | fix_we | tom2_we;
         prev_req   <= req_valid;
         prev_start <= req_start;
      end
   end

   logic start_low;
   assign start_low = (req_start[ADDR_W-1:20] == '0);

   // R1: one response per request, one cycle later
   assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2: no usable state gives the off code
   assert_off_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (!seen_def || en_q == 2'b00)) |=> (rsp_type == 8'hFF));

   // R5: variable enable clear outside the fixed table yields the default type
   assert_var_off_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seen_def && en_q == 2'b01 && (!start_low || !HAVE_FIXED))
      |=> (rsp_type == dflt_q));

   // R4: fixed-table result depends on start only
   assert_fixed_start_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (HAVE_FIXED && req_valid && prev_req && !wr_q && seen_def && en_q != 2'b00
       && start_low && req_start == prev_start) |=> $stable(rsp_type));

   logic unused_chk;
   assign unused_chk = ^{var_idx, var_sel_mask, var_wdata, fix_idx, fix_wdata, tom2_wdata, req_end};

endmodule

bind mtype_lookup mtype_lookup_chk #(
   .ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .HAVE_FIXED(HAVE_FIXED)
) u_chk (.*);

// File: tb/sim_mtype_lookup.sv
`timescale 1ns/1ps
module sim_mtype_lookup;

   localparam int AW = 40;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          def_we = 1'b0;
   logic [11:0]   def_wdata = '0;
   logic          var_we = 1'b0;
   logic [2:0]    var_idx = '0;
   logic          var_sel_mask = 1'b0;
   logic [AW-1:0] var_wdata = '0;
   logic          fix_we = 1'b0;
   logic [6:0]    fix_idx = '0;
   logic [7:0]    fix_wdata = '0;
   logic          tom2_we = 1'b0;
   logic [AW-1:0] tom2_wdata = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_start = '0;
   logic [AW-1:0] req_end = '0;
   logic          rsp_valid;
   logic [7:0]    rsp_type;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mtype_lookup #(.ADDR_W(AW), .NUM_VAR(NV)) u0 (.*);

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_def(input logic [11:0] w);
      @(negedge clk); def_we = 1'b1; def_wdata = w;
      @(negedge clk); def_we = 1'b0;
   endtask

   task automatic wr_var(input int idx, input logic msk, input logic [AW-1:0] w);
      @(negedge clk); var_we = 1'b1; var_idx = 3'(idx); var_sel_mask = msk; var_wdata = w;
      @(negedge clk); var_we = 1'b0;
   endtask

   task automatic wr_fix(input int idx, input logic [7:0] t);
      @(negedge clk); fix_we = 1'b1; fix_idx = 7'(idx); fix_wdata = t;
      @(negedge clk); fix_we = 1'b0;
   endtask

   task automatic wr_tom2(input logic [AW-1:0] v);
      @(negedge clk); tom2_we = 1'b1; tom2_wdata = v;
      @(negedge clk); tom2_we = 1'b0;
   endtask

   function automatic logic [AW-1:0] mk_mask(input logic [AW:0] size, input logic vld);
      logic [AW:0] m;
      m = ((41'h1 << AW) - size) & ~41'hFFF;
      return m[AW-1:0] | (vld ? 40'h800 : 40'h0);
   endfunction

   task automatic look(input logic [AW-1:0] s, input logic [AW-1:0] e,
                       input logic [7:0] exp, input string req);
      @(negedge clk); req_valid = 1'b1; req_start = s; req_end = e;
      @(negedge clk); req_valid = 1'b0;
      check({req, " valid"}, {7'd0, rsp_valid}, 8'h01);
      check(req, rsp_type, exp);
   endtask

   task automatic t_reset();
      check("R1 reset valid", {7'd0, rsp_valid}, 8'h00);
      check("R1 reset type", rsp_type, 8'h00);
      look(40'h200000, 40'h201000, 8'hFF, "R2 unloaded");
   endtask

   task automatic t_no_enable();
      wr_def(12'h006);
      look(40'h200000, 40'h201000, 8'hFF, "R2 both enables clear");
   endtask

   task automatic t_fixed();
      wr_def(12'hC06);
      wr_fix(3, 8'h05);
      wr_fix(10, 8'h01);
      wr_fix(29, 8'h04);
      wr_fix(87, 8'h00);
      wr_fix(88, 8'h05);
      look(40'h30000, 40'h31000, 8'h05, "R4 64K slot 3");
      look(40'h30000, 40'h4000000, 8'h05, "R4 end ignored");
      look(40'h88000, 40'h89000, 8'h01, "R4 16K slot 10");
      look(40'hC5000, 40'hC6000, 8'h04, "R4 4K slot 29");
      look(40'hFF000, 40'h100000, 8'h00, "R4 4K slot 87");
      // back-to-back pair, same start, different end
      @(negedge clk); req_valid = 1'b1; req_start = 40'h88000; req_end = 40'h89000;
      @(negedge clk); req_end = 40'h900000;
      check("R4 pair first", rsp_type, 8'h01);
      @(negedge clk); req_valid = 1'b0;
      check("R4 pair second", rsp_type, 8'h01);
   endtask

   task automatic t_var_disabled();
      wr_def(12'h405);
      look(40'h200000, 40'h201000, 8'h05, "R5 variable enable clear");
   endtask

   task automatic t_var_basic();
      wr_def(12'hC05);
      wr_var(0, 1'b0, 40'h1000000 | 40'h06);
      wr_var(0, 1'b1, mk_mask(41'h1000000, 1'b1));
      wr_var(1, 1'b0, 40'h1000000 | 40'h00);
      wr_var(1, 1'b1, mk_mask(41'h100000, 1'b0));
      look(40'h1000000, 40'h1001000, 8'h06, "R6 single range type");
      look(40'h1800000, 40'h1801000, 8'h06, "R6 invalid range ignored");
      look(40'h3000000, 40'h3001000, 8'h05, "R12 no match default");
      look(40'h0FFF000, 40'h1001000, 8'hFE, "R7 straddle low edge");
      look(40'h1000000, 40'h2000000, 8'h06, "R3 exclusive end inside");
      look(40'h1000000, 40'h2001000, 8'hFE, "R3 end past range");
   endtask

   task automatic t_overlap();
      wr_var(1, 1'b1, mk_mask(41'h100000, 1'b1));
      wr_var(1, 1'b0, 40'h1000000 | 40'h04);
      look(40'h1000000, 40'h1001000, 8'h04, "R9 WB with WT");
      wr_var(1, 1'b0, 40'h1000000 | 40'h00);
      look(40'h1000000, 40'h1001000, 8'h00, "R8 UC wins");
      wr_var(1, 1'b0, 40'h1000000 | 40'h01);
      look(40'h1000000, 40'h1001000, 8'h00, "R10 WB with WC");
      wr_var(1, 1'b0, 40'h1000000 | 40'h06);
      look(40'h1000000, 40'h1001000, 8'h06, "R10 equal types");
   endtask

   task automatic t_order();
      wr_var(1, 1'b0, 40'h1000000 | 40'h01);
      wr_var(2, 1'b0, 40'h1000000 | 40'h06);
      wr_var(2, 1'b1, mk_mask(41'h10000, 1'b1));
      look(40'h1000000, 40'h1020000, 8'h00, "R13 conflict before straddle");
      wr_var(1, 1'b1, mk_mask(41'h100000, 1'b0));
      look(40'h1000000, 40'h1020000, 8'hFE, "R13 straddle after match");
      wr_var(2, 1'b1, mk_mask(41'h10000, 1'b0));
   endtask

   task automatic t_tom2();
      look(40'h100000000, 40'h100100000, 8'h05, "R11 limit zero");
      wr_tom2(40'h200000000);
      look(40'h100000000, 40'h100100000, 8'h06, "R11 below limit");
      look(40'h100000000, 40'h200001000, 8'h05, "R11 past limit");
      look(40'h0F0000000, 40'h0F0001000, 8'h05, "R11 below 4GiB");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_enable();
      t_fixed();
      t_var_disabled();
      t_var_basic();
      t_overlap();
      t_order();
      t_tom2();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule